// File: doc/BRIEF.md
# Dual-Format Signed/Unsigned Multiplier with Fractional Scaling

This block is the multiply stage in front of a DSP accumulator path. It takes two 16-bit operands, each with its own flag saying whether it is two's complement or unsigned. Each operand is widened to 17 bits from that flag, so one signed 17-by-17 array covers signed, unsigned and mixed-sign products. The raw product is 33 bits wide.

In integer mode the product passes through unchanged. In fractional mode it is doubled, which turns a Q15 by Q15 product into a Q1.31 value. The result is then sign-extended to a 40-bit accumulator-width output. A narrow result port serves the register-file path. In word mode it carries the low 32 bits of the result. In byte mode only the low 8 bits of each operand are multiplied, and a 16-bit product is returned, zero-padded to 32 bits.

A single output register holds the result, an overflow-range flag and the valid bit. The register sits behind a valid/ready handshake, so the latency is one cycle and a stalled consumer holds the result in place.

Top module: `mulsc_top`

## Requirements
- R1: An operand flagged signed is sign-extended into bit 16 before multiplying. An operand flagged unsigned is zero-extended. In word integer mode, 0xFFFF times 0xFFFF gives 0x00_FFFE_0001 when both are unsigned and 0x00_0000_0001 when both are signed.
- R2: Mixed-sign products use the same array. A signed 0xFFFF (-1) times an unsigned 0xFFFF gives 0xFF_FFFF_0001 on `acc_prod`.
- R3: In integer mode `acc_prod` is the product sign-extended to 40 bits, so bits 39 down to 32 are all equal.
- R4: With `frac_mode`=1 and `byte_mode`=0, `acc_prod` is the product shifted left by one with a zero in bit 0 (Q15 x Q15 to Q1.31). For example, 0x4000 x 0x4000 gives 0x00_2000_0000.
- R5: Fractional -1.0 times -1.0 (0x8000 x 0x8000, both signed) gives 0x00_8000_0000 without wrapping, and raises `over_q31`.
- R6: `over_q31` is 1 exactly when bits 39 down to 31 of `acc_prod` are not all equal, that is, when the value lies outside the signed 32-bit range.
- R7: With `byte_mode`=1, only bits 7:0 of each operand are used, extended by the operand's sign flag. `reg_res` carries the 16-bit product in bits 15:0 with bits 31:16 zero, and `acc_prod` carries the product sign-extended.
- R8: With `byte_mode`=1, `frac_mode` is ignored and no scaling is applied.
- R9: In word mode, `reg_res` equals bits 31:0 of `acc_prod`.
- R10: A transfer accepted on a clock edge (`in_valid` and `in_ready`) appears on the outputs with `out_valid`=1 after that same edge. After a cycle with `out_ready`=1 and no new transfer, `out_valid` falls.
- R11: While `out_valid`=1 and `out_ready`=0, the outputs hold their values and no new operands are accepted.
- R12: `in_ready` equals NOT `out_valid` OR `out_ready`.
- R13: Synchronous active-low reset clears `out_valid`, `acc_prod`, `reg_res` and `over_q31` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and modes are valid |
| in_ready | output | 1 | Block can accept operands this cycle |
| a_op | input | 16 | Operand A |
| b_op | input | 16 | Operand B |
| a_signed | input | 1 | 1: A is two's complement; 0: unsigned |
| b_signed | input | 1 | 1: B is two's complement; 0: unsigned |
| frac_mode | input | 1 | 1: fractional (doubled) result; 0: integer |
| byte_mode | input | 1 | 1: 8-bit operands and 16-bit result; 0: 16-bit operands |
| out_valid | output | 1 | Result registers hold a valid product |
| out_ready | input | 1 | Consumer takes the result this cycle |
| acc_prod | output | 40 | Sign-extended product for the accumulator |
| reg_res | output | 32 | Narrow result for the register file |
| over_q31 | output | 1 | Result exceeds the signed 32-bit range |

## Verification
The bench builds the block with its default widths: 16-bit operands, an 8-bit byte lane and a 40-bit accumulator output. With these widths the extreme operand codes 0x8000, 0x7FFF and 0xFFFF can be listed directly, along with the fractional -1 x -1 case that lands just above the 32-bit range. A vector table covers every sign pairing in integer, fractional and byte modes, including byte operands that carry garbage in their upper halves. Directed steps cover reset, the one-cycle latency and a stall in which a second operand set waits until the consumer is ready.

// File: rtl/mulsc_pkg.sv
// Package: shared widths for the multiplier/scaler.
// Assumes operands are at least twice the byte-lane width.
package mulsc_pkg;
    localparam int DATA_W = 16;   // operand width
    localparam int BYTE_W = 8;    // byte-lane width
    localparam int ACC_W  = 40;   // accumulator-side output width
endpackage

// File: rtl/mulsc_opnd_ext.sv
// Operand extender: picks the byte or word lane of one operand and widens it
// to DATA_W+1 bits, sign- or zero-filled from its sign flag.
// Assumes BYTE_W < DATA_W.
module mulsc_opnd_ext #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int EXT_W = DATA_W + 1
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              is_signed,
    input  logic              byte_sel,
    output logic [EXT_W-1:0]  ext
);
    localparam int FILL_W = EXT_W - BYTE_W;

    // Select lane and fill the upper bits from the sign flag.
    always_comb begin
        if (byte_sel)
            ext = {{FILL_W{is_signed & raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
        else
            ext = {is_signed & raw[DATA_W-1], raw};
    end
endmodule

// File: rtl/mulsc_core.sv
// Multiplier array: one signed (DATA_W+1)x(DATA_W+1) multiply, result cut to
// 2*DATA_W+1 bits, which holds every product of two extended operands.
// Assumes inputs are already extended by mulsc_opnd_ext.
module mulsc_core #(
    parameter int DATA_W = 16,
    localparam int EXT_W = DATA_W + 1,
    localparam int PROD_W = 2 * DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EXT_W-1:0]  a_ext,
    input  logic [EXT_W-1:0]  b_ext,
    output logic [PROD_W-1:0] prod
);
    logic signed [2*EXT_W-1:0] full;

    // Full signed product of the extended operands.
    always_comb full = $signed(a_ext) * $signed(b_ext);

    // Narrow to the product width.
    always_comb prod = full[PROD_W-1:0];

    // R1: extended operands never produce a product wider than PROD_W.
    assert_prod_fits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        full[2*EXT_W-1] == full[2*EXT_W-2]);
endmodule

// File: rtl/mulsc_scale.sv
// Scaler/formatter: widens the product to ACC_W, doubles it in fractional word
// mode, builds the narrow register result and the 32-bit range flag.
// Assumes ACC_W >= PROD_W + 1 so the doubling cannot wrap.
module mulsc_scale #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40,
    localparam int PROD_W = 2 * DATA_W + 1,
    localparam int REG_W  = 2 * DATA_W,
    localparam int EXT_N  = ACC_W - PROD_W
) (
    input  logic [PROD_W-1:0] prod,
    input  logic              frac,
    input  logic              byte_sel,
    output logic [ACC_W-1:0]  acc_val,
    output logic [REG_W-1:0]  reg_val,
    output logic              over_rng
);
    logic [ACC_W-1:0] wide;
    logic [ACC_W-REG_W:0] top_bits;

    // Sign-extend the raw product before any shift so nothing wraps.
    always_comb wide = {{EXT_N{prod[PROD_W-1]}}, prod};

    // Fractional scaling applies in word mode only.
    always_comb acc_val = (frac && !byte_sel) ? {wide[ACC_W-2:0], 1'b0} : wide;

    // Byte mode returns DATA_W bits zero-padded; word mode returns REG_W bits.
    always_comb begin
        if (byte_sel)
            reg_val = {{(REG_W-DATA_W){1'b0}}, acc_val[DATA_W-1:0]};
        else
            reg_val = acc_val[REG_W-1:0];
    end

    // Out of signed REG_W range when the bits from REG_W-1 up differ.
    always_comb begin
        top_bits = acc_val[ACC_W-1:REG_W-1];
        over_rng = !((&top_bits) || (~|top_bits));
    end
endmodule

// File: rtl/mulsc_top.sv
// Multiplier/scaler top: two operand extenders, the array, the scaler and a
// single output register behind a valid/ready handshake (latency 1).
// Assumes the consumer may stall at any time; inputs are sampled on accept.
module mulsc_top #(
    parameter int DATA_W = mulsc_pkg::DATA_W,
    parameter int BYTE_W = mulsc_pkg::BYTE_W,
    parameter int ACC_W  = mulsc_pkg::ACC_W,
    localparam int EXT_W  = DATA_W + 1,
    localparam int PROD_W = 2 * DATA_W + 1,
    localparam int REG_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] a_op,
    input  logic [DATA_W-1:0] b_op,
    input  logic              a_signed,
    input  logic              b_signed,
    input  logic              frac_mode,
    input  logic              byte_mode,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ACC_W-1:0]  acc_prod,
    output logic [REG_W-1:0]  reg_res,
    output logic              over_q31
);
    logic [DATA_W-1:0] raw_v [2];
    logic              sgn_v [2];
    logic [EXT_W-1:0]  ext_v [2];
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  acc_d;
    logic [REG_W-1:0]  reg_d;
    logic              ovr_d;
    logic              accept;
    logic              valid_q;
    logic              frac_q;
    logic [ACC_W-1:0]  acc_q;
    logic [REG_W-1:0]  reg_q;
    logic              ovr_q;

    // Gather the two operands for the extender array.
    always_comb begin
        raw_v[0] = a_op;  sgn_v[0] = a_signed;
        raw_v[1] = b_op;  sgn_v[1] = b_signed;
    end

    for (genvar i = 0; i < 2; i++) begin : g_ext
        mulsc_opnd_ext #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext (
            .raw(raw_v[i]), .is_signed(sgn_v[i]), .byte_sel(byte_mode),
            .ext(ext_v[i]));
    end

    mulsc_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .a_ext(ext_v[0]), .b_ext(ext_v[1]),
        .prod(prod));

    mulsc_scale #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_scale (
        .prod(prod), .frac(frac_mode), .byte_sel(byte_mode),
        .acc_val(acc_d), .reg_val(reg_d), .over_rng(ovr_d));

    // Ready when the output slot is empty or being drained.
    always_comb in_ready = !valid_q || out_ready;
    always_comb accept = in_valid && in_ready;

    // Output register: load on accept, drop valid once drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            frac_q  <= 1'b0;
            acc_q   <= '0;
            reg_q   <= '0;
            ovr_q   <= 1'b0;
        end else if (accept) begin
            valid_q <= 1'b1;
            frac_q  <= frac_mode && !byte_mode;
            acc_q   <= acc_d;
            reg_q   <= reg_d;
            ovr_q   <= ovr_d;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    // Drive the ports from the output register.
    always_comb begin
        out_valid = valid_q;
        acc_prod  = acc_q;
        reg_res   = reg_q;
        over_q31  = ovr_q;
    end

    // R10: an accepted transfer shows up valid one cycle later.
    assert_accept_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R11: a stalled result holds still and stays valid.
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(acc_prod)
                                       && $stable(reg_res) && $stable(over_q31)));

    // R12: no acceptance while a stalled result is held.
    assert_ready_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R3: integer results are sign-extended through the guard bits.
    assert_int_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !frac_q) |-> ((&acc_prod[ACC_W-1:REG_W]) || (~|acc_prod[ACC_W-1:REG_W])));

    // R4: fractional results always have a zero LSB.
    assert_frac_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && frac_q) |-> !acc_prod[0]);

    // R13: the cycle after reset the output is empty.
    assert_reset_empty_R13: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/tb_mulsc_top.sv
// Bench: a vector table walked by one loop, then directed reset and
// handshake tests. Inputs change at negedges, outputs are sampled at negedges.
module tb_mulsc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] a_op = '0;
    logic [15:0] b_op = '0;
    logic        a_signed = 1'b0;
    logic        b_signed = 1'b0;
    logic        frac_mode = 1'b0;
    logic        byte_mode = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [39:0] acc_prod;
    logic [31:0] reg_res;
    logic        over_q31;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    mulsc_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .a_op(a_op), .b_op(b_op), .a_signed(a_signed), .b_signed(b_signed),
        .frac_mode(frac_mode), .byte_mode(byte_mode), .out_valid(out_valid),
        .out_ready(out_ready), .acc_prod(acc_prod), .reg_res(reg_res),
        .over_q31(over_q31));

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        as;
        logic        bs;
        logic        fr;
        logic        by;
        logic [39:0] acc;
        logic [31:0] rr;
        logic        ov;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_FFFE_0001, 32'hFFFE_0001, 1'b1, 8'd1}, // R1 unsigned
        '{16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 40'h00_0000_0001, 32'h0000_0001, 1'b0, 8'd1}, // R1 signed
        '{16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 40'hFF_FFFF_0001, 32'hFFFF_0001, 1'b0, 8'd2}, // R2
        '{16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b0, 1'b0, 40'hFF_C000_8000, 32'hC000_8000, 1'b0, 8'd3}, // R3
        '{16'h7FFF, 16'h8000, 1'b0, 1'b1, 1'b0, 1'b0, 40'hFF_C000_8000, 32'hC000_8000, 1'b0, 8'd2}, // R2
        '{16'h4000, 16'h4000, 1'b1, 1'b1, 1'b1, 1'b0, 40'h00_2000_0000, 32'h2000_0000, 1'b0, 8'd4}, // R4
        '{16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, 40'h00_8000_0000, 32'h8000_0000, 1'b1, 8'd5}, // R5
        '{16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b0, 40'hFF_8001_0000, 32'h8001_0000, 1'b0, 8'd4}, // R4
        '{16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b0, 40'h00_7FFE_0002, 32'h7FFE_0002, 1'b0, 8'd9}, // R9
        '{16'h12FE, 16'h3403, 1'b1, 1'b1, 1'b0, 1'b1, 40'hFF_FFFF_FFFA, 32'h0000_FFFA, 1'b0, 8'd7}, // R7
        '{16'h12FE, 16'h3403, 1'b0, 1'b0, 1'b0, 1'b1, 40'h00_0000_02FA, 32'h0000_02FA, 1'b0, 8'd7}, // R7
        '{16'hAA80, 16'h5580, 1'b1, 1'b1, 1'b1, 1'b1, 40'h00_0000_4000, 32'h0000_4000, 1'b0, 8'd8}, // R8
        '{16'h00FF, 16'h00FF, 1'b1, 1'b0, 1'b0, 1'b1, 40'hFF_FFFF_FF01, 32'h0000_FF01, 1'b0, 8'd7}  // R7 mixed
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        a_op = v.a; b_op = v.b; a_signed = v.as; b_signed = v.bs;
        frac_mode = v.fr; byte_mode = v.by;
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13 out_valid", 64'(out_valid), 64'd0);
        chk("R13 acc_prod", 64'(acc_prod), 64'd0);
        chk("R13 reg_res", 64'(reg_res), 64'd0);
        chk("R13 over_q31", 64'(over_q31), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 in_ready idle", 64'(in_ready), 64'd1);

        // Table walk: one transfer per vector, result checked a cycle later.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("R%0d valid v%0d", VECS[i].req, i), 64'(out_valid), 64'd1);
            chk($sformatf("R%0d acc v%0d", VECS[i].req, i), 64'(acc_prod), 64'(VECS[i].acc));
            chk($sformatf("R%0d reg v%0d", VECS[i].req, i), 64'(reg_res), 64'(VECS[i].rr));
            chk($sformatf("R%0d ovr v%0d R6", VECS[i].req, i), 64'(over_q31), 64'(VECS[i].ov));
        end
        @(negedge clk);
        // R10: drained with no new transfer
        chk("R10 valid falls", 64'(out_valid), 64'd0);

        // Stall: hold vector 6, offer vector 3 while the consumer is busy.
        out_ready = 1'b0;
        drive(VECS[6]);
        in_valid = 1'b1;
        @(negedge clk);
        chk("R10 valid after accept", 64'(out_valid), 64'd1);
        chk("R12 not ready in stall", 64'(in_ready), 64'd0);
        drive(VECS[3]);
        @(negedge clk);
        chk("R11 acc held", 64'(acc_prod), 64'h00_8000_0000);
        chk("R11 ovr held", 64'(over_q31), 64'd1);
        chk("R11 valid held", 64'(out_valid), 64'd1);
        out_ready = 1'b1;
        #0.1;
        chk("R12 ready when drained", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 waiting set taken", 64'(acc_prod), 64'hFF_C000_8000);
        chk("R11 waiting reg", 64'(reg_res), 64'hC000_8000);
        @(negedge clk);
        chk("R10 empty again", 64'(out_valid), 64'd0);

        // R13: reset while holding a result
        drive(VECS[0]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R13 mid reset valid", 64'(out_valid), 64'd0);
        chk("R13 mid reset acc", 64'(acc_prod), 64'd0);
        chk("R13 mid reset ovr", 64'(over_q31), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule